// File: doc/BRIEF.md
# Two-Bank Interrupt Controller with Normal and Fast Request Groups

This block gathers 64 peripheral interrupt lines into two processor request outputs: a normal request and a fast request. The lines are handled in two banks of 32, lines 0 to 31 and lines 32 to 63. Each bank has two independent register groups. One group feeds the normal request and the other feeds the fast request. Each group can program each line for level or edge sensing and for either polarity. Edge events stay latched until software writes ones to clear them.

Software reaches the groups through a plain 32-bit register bus at a fixed, sparse address map. No priority encoding or vector is produced. A handler reads the masked status words and picks the line it wants to serve.

Top module: `dbank_intc`

## Requirements
- R1: After reset, every enable, trigger-mode and polarity word reads zero, every masked status word reads zero, and both `irq_req` and `fiq_req` are low.
- R2: Group bases are fixed: low-bank normal at 0x00, low-bank fast at 0x20, high-bank normal at 0x60, high-bank fast at 0x80. The groups keep separate state, so enabling a line in one group leaves the status of the other groups unchanged.
- R3: Within a group, the words sit at the following offsets: +0x00 raw input, +0x04 enable, +0x08 clear (reads 0), +0x0C trigger mode, +0x10 polarity, +0x14 masked status, and +0x18/+0x1C reserved (read 0). A level line with polarity 0 is pending while its input is high. Its status bit shows this two clock edges after the input changes.
- R4: A polarity bit of 1 makes a level line pending while its input is low.
- R5: A trigger-mode bit of 1 with polarity 0 latches a rising edge. The status bit appears three clock edges after the input rises and stays set after the input falls.
- R6: In edge mode with polarity 1, only a falling edge latches. A rising edge leaves status at zero.
- R7: Writing a 1 to a clear bit drops that line's latched edge at the write edge. Writing a 0 has no effect. On a level line still active, a clear write has no lasting effect.
- R8: A cleared enable bit forces that line's status bit and its request contribution to zero. A latched edge is kept and shows again when the line is re-enabled.
- R9: `irq_req` is the OR of all status bits of the two normal groups. `fiq_req` is the OR of all status bits of the two fast groups.
- R10: 0x50 reads the revision word and 0x54 reads the feature word. Both ignore writes. 0x40 to 0x4C and 0x58 to 0x5C read zero.
- R11: The raw input word of a group returns its bank's inputs after two synchronizing stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 64 | Asynchronous peripheral interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_req | output | 1 | Normal interrupt request |
| fiq_req | output | 1 | Fast interrupt request |

## Verification
An input change passes two synchronizer stages. A level-sensed line therefore reaches its status word after two clock edges, and a latched edge needs a third edge. Register writes and clear writes take effect at the edge that captures them. Read data and both request outputs are combinational, so they can be read in the same cycle.

The bench drives every stimulus on a falling edge and counts rising edges before each expected value is queued. The monitor compares the result one nanosecond after the read address is set, well away from the next rising edge. Back-to-back reads after an edge stimulus check the cycle before the latch fills and the cycle after it.

// File: rtl/dbank_intc.sv
module dbank_intc #(
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] REV_WORD  = 32'h0001_0200,
  parameter logic [31:0] FEAT_WORD = 32'h0000_0440
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       line_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_req,
  output logic              fiq_req
);
  localparam int NGRP = 4;

  logic [63:0] sync_a, sync_b, prev_b;
  logic [NGRP-1:0][31:0] en_r, mode_r, lev_r, lat_r;
  logic [NGRP-1:0][31:0] raw_g, stat_g;

  logic [2:0] page;
  logic [2:0] word;
  logic       grp_ok;
  logic [1:0] grp;

  assign page = bus_addr[7:5];
  assign word = bus_addr[4:2];
  assign grp_ok = (page == 3'd0) || (page == 3'd1) || (page == 3'd3) || (page == 3'd4);
  assign grp = (page == 3'd0) ? 2'd0 :
               (page == 3'd1) ? 2'd1 :
               (page == 3'd3) ? 2'd2 : 2'd3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev_b <= '0;
    end else begin
      sync_a <= line_in;
      sync_b <= sync_a;
      prev_b <= sync_b;
    end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [31:0] raw, old, evt, pend, clr;
    logic        wsel;

    assign raw  = g[1] ? sync_b[63:32] : sync_b[31:0];
    assign old  = g[1] ? prev_b[63:32] : prev_b[31:0];
    assign evt  = mode_r[g] & ((~lev_r[g] & raw & ~old) | (lev_r[g] & ~raw & old));
    assign pend = (mode_r[g] & lat_r[g]) | (~mode_r[g] & (raw ^ lev_r[g]));
    assign wsel = bus_sel && bus_wr && grp_ok && (grp == 2'(g));
    assign clr  = (wsel && word == 3'd2) ? bus_wdata : '0;

    assign raw_g[g]  = raw;
    assign stat_g[g] = pend & en_r[g];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        en_r[g]   <= '0;
        mode_r[g] <= '0;
        lev_r[g]  <= '0;
        lat_r[g]  <= '0;
      end else begin
        if (wsel && word == 3'd1) en_r[g]   <= bus_wdata;
        if (wsel && word == 3'd3) mode_r[g] <= bus_wdata;
        if (wsel && word == 3'd4) lev_r[g]  <= bus_wdata;
        lat_r[g] <= (lat_r[g] & ~clr) | evt;
      end
  end

  always_comb begin
    bus_rdata = '0;
    if (grp_ok)
      case (word)
        3'd0:    bus_rdata = raw_g[grp];
        3'd1:    bus_rdata = en_r[grp];
        3'd3:    bus_rdata = mode_r[grp];
        3'd4:    bus_rdata = lev_r[grp];
        3'd5:    bus_rdata = stat_g[grp];
        default: bus_rdata = '0;
      endcase
    else if (page == 3'd2 && word == 3'd4)
      bus_rdata = REV_WORD;
    else if (page == 3'd2 && word == 3'd5)
      bus_rdata = FEAT_WORD;
  end

  assign irq_req = (|stat_g[0]) | (|stat_g[2]);
  assign fiq_req = (|stat_g[1]) | (|stat_g[3]);
endmodule

// File: rtl/dbank_intc_chk.sv
module dbank_intc_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq_req,
  input logic              fiq_req,
  input logic [3:0][31:0]  en_r,
  input logic [3:0][31:0]  lat_r
);
  logic [31:0] en_sel;
  logic        stat_rd;
  logic        clr_wr;

  always_comb begin
    en_sel = '0;
    case (bus_addr[7:5])
      3'd0: en_sel = en_r[0];
      3'd1: en_sel = en_r[1];
      3'd3: en_sel = en_r[2];
      3'd4: en_sel = en_r[3];
      default: en_sel = '0;
    endcase
  end

  assign stat_rd = (bus_addr[7:5] != 3'd2) && (bus_addr[7:5] <= 3'd4) && (bus_addr[4:2] == 3'd5);
  assign clr_wr  = bus_sel && bus_wr && (bus_addr[4:2] == 3'd2);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_req && !fiq_req));

  // R8
  stat_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> ((bus_rdata & ~en_sel) == 32'd0));

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r[0] == 32'd0 && en_r[2] == 32'd0) |-> !irq_req);

  // R9
  fiq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r[1] == 32'd0 && en_r[3] == 32'd0) |-> !fiq_req);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (($past(lat_r) & ~lat_r) == 128'd0));

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[7:4] == 4'h4) |-> (bus_rdata == 32'd0));
endmodule

bind dbank_intc dbank_intc_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_req(irq_req),
  .fiq_req(fiq_req), .en_r(en_r), .lat_r(lat_r)
);

// File: tb/dbank_intc_tb_top.sv
`timescale 1ns/100ps
module dbank_intc_tb_top;
  localparam logic [31:0] REV  = 32'h0001_0200;
  localparam logic [31:0] FEAT = 32'h0000_0440;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] line_in = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req, fiq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  event smp_ev;

  always #2 clk = ~clk;

  dbank_intc #(.ADDR_W(8), .REV_WORD(REV), .FEAT_WORD(FEAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .fiq_req(fiq_req)
  );

  initial begin
    forever begin
      @(smp_ev);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'd0, irq_req} : {31'd0, fiq_req};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h", it.tag, it.kind, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.kind = 0; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> smp_ev;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic out(input int k, input logic e, input string tag);
    item_t it;
    it.kind = k; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    -> smp_ev;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    rd(8'h04, 32'h0, "R1 enable reset");
    rd(8'h8C, 32'h0, "R1 mode reset");
    rd(8'h70, 32'h0, "R1 polarity reset");
    rd(8'h14, 32'h0, "R1 status reset");
    out(1, 1'b0, "R1 irq reset");
    out(2, 1'b0, "R1 fiq reset");

    rd(8'h50, REV, "R10 revision");
    rd(8'h54, FEAT, "R10 feature");
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, REV, "R10 revision write ignored");
    rd(8'h44, 32'h0, "R10 reserved gap");
    rd(8'h5C, 32'h0, "R10 reserved tail");
    rd(8'h18, 32'h0, "R3 reserved group word");

    wr(8'h04, 32'h8);
    line_in[3] = 1'b1;
    tick(1);
    rd(8'h14, 32'h0, "R3 level not yet");
    rd(8'h14, 32'h8, "R3 level after two edges");
    out(1, 1'b1, "R9 irq from low normal group");
    out(2, 1'b0, "R9 fiq stays low");
    line_in[3] = 1'b0;
    tick(2);
    rd(8'h14, 32'h0, "R3 level released");

    line_in[3] = 1'b1;
    tick(2);
    wr(8'h08, 32'h8);
    rd(8'h14, 32'h8, "R7 clear on active level");
    line_in[3] = 1'b0;
    tick(2);

    wr(8'h04, 32'h18);
    wr(8'h10, 32'h10);
    rd(8'h14, 32'h10, "R4 active low pending");
    line_in[4] = 1'b1;
    tick(2);
    rd(8'h14, 32'h0, "R4 active low released");

    wr(8'h8C, 32'h1);
    wr(8'h84, 32'h1);
    line_in[32] = 1'b1;
    tick(2);
    rd(8'h94, 32'h0, "R5 edge not yet latched");
    rd(8'h94, 32'h1, "R5 edge latched");
    out(2, 1'b1, "R9 fiq from high fast group");
    out(1, 1'b0, "R9 irq unaffected");
    line_in[32] = 1'b0;
    tick(3);
    rd(8'h94, 32'h1, "R5 latch holds after fall");
    wr(8'h88, 32'h0);
    rd(8'h94, 32'h1, "R7 zero clear no effect");
    wr(8'h88, 32'h1);
    rd(8'h94, 32'h0, "R7 one clears latch");
    out(2, 1'b0, "R7 fiq drops after clear");

    wr(8'h6C, 32'h2);
    wr(8'h70, 32'h2);
    wr(8'h64, 32'h2);
    line_in[33] = 1'b1;
    tick(3);
    rd(8'h74, 32'h0, "R6 rising ignored in falling mode");
    line_in[33] = 1'b0;
    tick(3);
    rd(8'h74, 32'h2, "R6 falling edge latched");
    out(1, 1'b1, "R6 irq raised");

    wr(8'h64, 32'h0);
    rd(8'h74, 32'h0, "R8 disabled status");
    out(1, 1'b0, "R8 disabled request");
    wr(8'h64, 32'h2);
    rd(8'h74, 32'h2, "R8 latch kept while disabled");
    wr(8'h68, 32'h2);
    rd(8'h74, 32'h0, "R7 high bank clear");

    wr(8'h24, 32'h20);
    line_in[5] = 1'b1;
    tick(2);
    rd(8'h34, 32'h20, "R2 low fast group status");
    out(2, 1'b1, "R2 fiq from low fast group");
    rd(8'h14, 32'h0, "R2 low normal group untouched");
    out(1, 1'b0, "R2 irq untouched");

    line_in[63] = 1'b1;
    tick(2);
    rd(8'h60, 32'h8000_0000, "R11 high raw word");
    rd(8'h20, 32'h0000_0030, "R11 low raw word");
    rd(8'h00, 32'h0000_0030, "R11 low raw word normal group");

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule